// File: doc/BRIEF.md
# Multi-Cycle Integer RISC Core

A compact processor for a 32-bit load/store integer instruction subset. Every instruction walks a fixed sequence of controller states. The core fetches the instruction word, bumps the program counter by four, reads the two source registers, and then executes. Loads and stores take one extra memory step. Because the counter has already moved on before execution, branch and jump targets are formed from the address of the following instruction.

The core owns a 32 x 32-bit register file, in which entry zero is hard-wired to zero, and a single ALU. Instructions and data share one word memory. The core reaches it through a request/valid handshake: the core raises `mem_req` with an address, plus `mem_we` and write data for a store, and holds all of them until the memory answers with `mem_valid`. On a read, the word arrives on `mem_rdata` in the same cycle as `mem_valid`.

Two sticky flags report trouble. The first is set when a word access has a nonzero address low pair; that access never reaches memory. The second is set when an opcode or function code is not recognised; such a word behaves as a no-op. Only reset clears the flags.

Controller states:
- `ST_FETCH`: request the word at the PC, and wait in this state until `mem_valid` arrives.
- `ST_ADVANCE`: add 4 to the PC.
- `ST_DECODE`: latch both source registers.
- `ST_EXEC`: compute, write the result back, and redirect the PC for a branch or jump.
- `ST_MEMACC`: perform the data access, and wait in this state until `mem_valid` arrives.

Transitions:
- FETCH to ADVANCE on `mem_valid`.
- ADVANCE to DECODE, unconditionally.
- DECODE to EXEC, unconditionally.
- EXEC to MEMACC for an aligned load or store.
- EXEC to FETCH for every other instruction.
- MEMACC to FETCH on `mem_valid`.

Top module: `mcp_core`

## Requirements
- R1: Reset sets the PC to 0, enters ST_FETCH and clears both flags; the first request after reset reads address 0.
- R2: The states run FETCH, ADVANCE, DECODE, EXEC and then back to FETCH, with MEMACC inserted for an aligned load or store. The PC grows by 4 in ADVANCE. With a memory that answers one cycle after a request, an ALU instruction takes 5 cycles and a load takes 7.
- R3: A request keeps its address, write enable and data steady until `mem_valid`, and each executed store produces exactly one write.
- R4: Register 0 always reads as zero, and writes aimed at it are dropped.
- R5: The register-register forms (opcode in bits 31:26 = 0, function code in bits 5:0) are add 0x20, sub 0x22, and 0x24, or 0x25 and nor 0x27. Sources sit in bits 25:21 and 20:16, and the destination in bits 15:11.
- R6: Shift left 0x00 and logical shift right 0x02 shift the bits 20:16 register by the amount in bits 10:6.
- R7: Set-less-than (function 0x2A, or opcode 0x0A with an immediate) writes 1 when the first operand is below the second in signed order, and 0 otherwise.
- R8: Immediate forms write the register in bits 20:16. Add-immediate (0x08) sign-extends bits 15:0. And-immediate (0x0C) and or-immediate (0x0D) zero-extend them. Upper-immediate (0x0F) writes imm<<16, so 0xa532 followed by an or-immediate of 0x8d7e gives 0xa5328d7e.
- R9: Load word (0x23) and store word (0x2B) address base register + sign-extended offset. A store drives the bits 20:16 register on `mem_wdata`.
- R10: Branch-if-equal (0x04) and branch-if-unequal (0x05) go to PC+4 + (sign-extended offset << 2) when taken, and to PC+4 otherwise.
- R11: Jump (0x02) goes to {PC+4[31:28], bits 25:0, 2'b00}.
- R12: A load or store with a nonzero address low pair sets `misalign_err`, which stays set until reset. No request is issued and no register changes.
- R13: An unknown opcode or function code changes only the PC and sets `illegal_op`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Memory request, held until mem_valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, always word aligned |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid with mem_valid |
| mem_valid | input | 1 | Memory completion strobe |
| misalign_err | output | 1 | Sticky misaligned-access flag |
| illegal_op | output | 1 | Sticky unknown-instruction flag |

## Verification
The hardest behaviour to prove from the ports is that nothing happens in three cases: an unknown function code whose destination field names a live register, a misaligned load, and a misaligned store. The register file is not visible, so the program places a store immediately after each suppressed instruction. That store exposes the register the faulty word would have overwritten. The bench also counts every write, so a leaked misaligned store is caught. Untaken paths are checked by confirming that the addresses of the skipped words are never fetched.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
    localparam int XLEN = 32;

    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_JMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ  = 6'h04;
    localparam logic [5:0] OPC_BNE  = 6'h05;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_SLTI = 6'h0A;
    localparam logic [5:0] OPC_ANDI = 6'h0C;
    localparam logic [5:0] OPC_ORI  = 6'h0D;
    localparam logic [5:0] OPC_LUI  = 6'h0F;
    localparam logic [5:0] OPC_LW   = 6'h23;
    localparam logic [5:0] OPC_SW   = 6'h2B;

    localparam logic [5:0] FN_SLL = 6'h00;
    localparam logic [5:0] FN_SRL = 6'h02;
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_NOR = 6'h27;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ST_FETCH, ST_ADVANCE, ST_DECODE, ST_EXEC, ST_MEMACC
    } cpu_state_t;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR,
        ALU_SLT, ALU_SLL, ALU_SRL, ALU_LUI
    } alu_op_t;

    typedef enum logic [2:0] {
        K_NOP, K_ALU, K_LOAD, K_STORE, K_BEQ, K_BNE, K_JUMP
    } instr_kind_t;

    typedef struct packed {
        instr_kind_t     kind;
        alu_op_t         op;
        logic            use_imm;
        logic [XLEN-1:0] imm;
        logic [4:0]      dst;
        logic            bad;
    } ctl_t;
endpackage

// File: rtl/mcp_regfile.sv
module mcp_regfile #(
    parameter int NREG = 32,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] ra_a,
    input  logic [IW-1:0] ra_b,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [DW-1:0] wd
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
endmodule

// File: rtl/mcp_alu.sv
module mcp_alu
    import mcp_pkg::*;
#(
    parameter int DW = XLEN
) (
    input  alu_op_t       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [4:0]    sh,
    output logic [DW-1:0] y
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_NOR: y = ~(a | b);
            ALU_SLT: y = {{(DW-1){1'b0}}, $signed(a) < $signed(b)};
            ALU_SLL: y = b << sh;
            ALU_SRL: y = b >> sh;
            ALU_LUI: y = b << (DW/2);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/mcp_decode.sv
module mcp_decode
    import mcp_pkg::*;
(
    input  logic [XLEN-1:0] ir,
    output ctl_t            ctl
);
    logic [5:0]      opc, fn;
    logic [XLEN-1:0] sext, zext;

    assign opc  = ir[31:26];
    assign fn   = ir[5:0];
    assign sext = {{(XLEN-16){ir[15]}}, ir[15:0]};
    assign zext = {{(XLEN-16){1'b0}}, ir[15:0]};

    always_comb begin
        ctl.kind    = K_NOP;
        ctl.op      = ALU_ADD;
        ctl.use_imm = 1'b1;
        ctl.imm     = sext;
        ctl.dst     = ir[20:16];
        ctl.bad     = 1'b0;
        case (opc)
            OPC_REG: begin
                ctl.kind    = K_ALU;
                ctl.use_imm = 1'b0;
                ctl.dst     = ir[15:11];
                case (fn)
                    FN_ADD:  ctl.op = ALU_ADD;
                    FN_SUB:  ctl.op = ALU_SUB;
                    FN_AND:  ctl.op = ALU_AND;
                    FN_OR:   ctl.op = ALU_OR;
                    FN_NOR:  ctl.op = ALU_NOR;
                    FN_SLT:  ctl.op = ALU_SLT;
                    FN_SLL:  ctl.op = ALU_SLL;
                    FN_SRL:  ctl.op = ALU_SRL;
                    default: begin
                        ctl.kind = K_NOP;
                        ctl.bad  = 1'b1;
                    end
                endcase
            end
            OPC_ADDI: ctl.kind = K_ALU;
            OPC_SLTI: begin ctl.kind = K_ALU; ctl.op = ALU_SLT; end
            OPC_ANDI: begin ctl.kind = K_ALU; ctl.op = ALU_AND; ctl.imm = zext; end
            OPC_ORI:  begin ctl.kind = K_ALU; ctl.op = ALU_OR;  ctl.imm = zext; end
            OPC_LUI:  begin ctl.kind = K_ALU; ctl.op = ALU_LUI; ctl.imm = zext; end
            OPC_LW:   ctl.kind = K_LOAD;
            OPC_SW:   ctl.kind = K_STORE;
            OPC_BEQ:  ctl.kind = K_BEQ;
            OPC_BNE:  ctl.kind = K_BNE;
            OPC_JMP:  ctl.kind = K_JUMP;
            default:  ctl.bad  = 1'b1;
        endcase
    end
endmodule

// File: rtl/mcp_core.sv
module mcp_core
    import mcp_pkg::*;
#(
    parameter int          NREG     = 32,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_valid,
    output logic        misalign_err,
    output logic        illegal_op
);
    localparam int RIW = $clog2(NREG);

    cpu_state_t      state, state_nx;
    logic [XLEN-1:0] pc, ir, a_q, b_q, maddr_q;
    logic [XLEN-1:0] rf_a, rf_b, alu_y, rf_wd;
    logic            rf_we, taken, is_mem, aligned;
    ctl_t            ctl;

    mcp_decode u_dec (.ir(ir), .ctl(ctl));

    mcp_regfile #(.NREG(NREG), .DW(XLEN)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .ra_a(ir[21 +: RIW]), .ra_b(ir[16 +: RIW]),
        .rd_a(rf_a), .rd_b(rf_b),
        .we(rf_we), .wa(ctl.dst[RIW-1:0]), .wd(rf_wd)
    );

    mcp_alu #(.DW(XLEN)) u_alu (
        .op(ctl.op), .a(a_q), .b(ctl.use_imm ? ctl.imm : b_q),
        .sh(ir[10:6]), .y(alu_y)
    );

    assign taken   = (ctl.kind == K_BEQ && a_q == b_q) ||
                     (ctl.kind == K_BNE && a_q != b_q);
    assign is_mem  = (ctl.kind == K_LOAD) || (ctl.kind == K_STORE);
    assign aligned = (alu_y[1:0] == 2'b00);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH:   if (mem_valid) state_nx = ST_ADVANCE;
            ST_ADVANCE: state_nx = ST_DECODE;
            ST_DECODE:  state_nx = ST_EXEC;
            ST_EXEC:    state_nx = (is_mem && aligned) ? ST_MEMACC : ST_FETCH;
            ST_MEMACC:  if (mem_valid) state_nx = ST_FETCH;
            default:    state_nx = ST_FETCH;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = (state == ST_FETCH) || (state == ST_MEMACC);
        mem_we    = (state == ST_MEMACC) && (ctl.kind == K_STORE);
        mem_addr  = (state == ST_MEMACC) ? maddr_q : pc;
        mem_wdata = b_q;
        rf_we     = ((state == ST_EXEC) && (ctl.kind == K_ALU)) ||
                    ((state == ST_MEMACC) && mem_valid && (ctl.kind == K_LOAD));
        rf_wd     = (state == ST_MEMACC) ? mem_rdata : alu_y;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc           <= RESET_PC;
            ir           <= '0;
            a_q          <= '0;
            b_q          <= '0;
            maddr_q      <= '0;
            misalign_err <= 1'b0;
            illegal_op   <= 1'b0;
        end else begin
            unique case (state)
                ST_FETCH:   if (mem_valid) ir <= mem_rdata;
                ST_ADVANCE: pc <= pc + 32'd4;
                ST_DECODE: begin
                    a_q <= rf_a;
                    b_q <= rf_b;
                end
                ST_EXEC: begin
                    maddr_q <= alu_y;
                    if (taken)                 pc <= pc + {ctl.imm[XLEN-3:0], 2'b00};
                    if (ctl.kind == K_JUMP)    pc <= {pc[31:28], ir[25:0], 2'b00};
                    if (is_mem && !aligned)    misalign_err <= 1'b1;
                    if (ctl.bad)               illegal_op   <= 1'b1;
                end
                ST_MEMACC: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mcp_core_chk.sv
module mcp_core_chk
    import mcp_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input cpu_state_t  state,
    input logic [31:0] pc,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_valid,
    input logic        misalign_err,
    input logic        illegal_op,
    input logic [31:0] r0_q
);
    // R1
    reset_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (state == ST_FETCH && mem_addr == 32'h0));

    // R2
    advance_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ADVANCE |=> (pc == $past(pc) + 32'd4 && state == ST_DECODE));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && (!mem_we || $stable(mem_wdata))));

    // R4
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r0_q == 32'h0);

    // R12
    aligned_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    // R12
    misalign_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_err |=> misalign_err);

    // R13
    illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |=> illegal_op);
endmodule

bind mcp_core mcp_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .pc(pc),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_valid(mem_valid),
    .misalign_err(misalign_err), .illegal_op(illegal_op),
    .r0_q(u_rf.regs[0])
);

// File: tb/tb_mcp_core.sv
`timescale 1ns/1ps
module tb_mcp_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req, mem_we, mem_valid = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        misalign_err, illegal_op;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    mcp_core dut (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_valid(mem_valid), .misalign_err(misalign_err), .illegal_op(illegal_op)
    );

    // memory model: answers one cycle after a request
    logic [31:0] mem [256];
    logic [31:0] wlog_addr [64];
    logic [31:0] wlog_data [64];
    int          wcnt = 0;
    bit          logging = 1'b1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_valid <= rst_n && mem_req && !mem_valid;
        if (rst_n && mem_req && !mem_valid) begin
            mem_rdata <= mem[mem_addr[9:2]];
            if (mem_we) begin
                mem[mem_addr[9:2]] <= mem_wdata;
                if (logging && wcnt < 64) begin
                    wlog_addr[wcnt] <= mem_addr;
                    wlog_data[wcnt] <= mem_wdata;
                end
                wcnt <= wcnt + 1;
            end
        end
    end

    // request-start monitor
    int   fetch_at [256];
    bit   mis_at [256];
    bit   ill_at [256];
    logic prev_req = 1'b0;
    logic [31:0] first_addr;
    bit   got_first = 1'b0;

    always @(negedge clk) begin
        if (rst_n && mem_req && !mem_we && !mem_valid) begin
            fetch_at[mem_addr[9:2]] = cyc;
            mis_at[mem_addr[9:2]]   = misalign_err;
            ill_at[mem_addr[9:2]]   = illegal_op;
            if (!got_first) begin
                first_addr = mem_addr;
                got_first  = 1'b1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt,
                                          logic [4:0] rd, logic [4:0] sh);
        return {6'h00, rs, rt, rd, sh, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                          logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction
    function automatic logic [31:0] enc_j(logic [25:0] idx);
        return {6'h02, idx};
    endfunction

    // expected writes, in order: {address, data}
    localparam int NW = 17;
    localparam logic [63:0] EXP_WR [NW] = '{
        {32'h200, 32'ha5328d7e}, {32'h204, 32'h00000002}, {32'h208, 32'hfffffff4},
        {32'h20c, 32'ha5328d7a}, {32'h210, 32'h5acd7280}, {32'h214, 32'h00000001},
        {32'h218, 32'h00000000}, {32'h21c, 32'h00000070}, {32'h220, 32'h00a5328d},
        {32'h224, 32'h0000ff00}, {32'h228, 32'h00000000}, {32'h234, 32'ha5328d7e},
        {32'h238, 32'h00000002}, {32'h23c, 32'h5acd7280}, {32'h240, 32'h00000000},
        {32'h244, 32'h00000007}, {32'h248, 32'h00000001}
    };
    localparam string EXP_TAG [NW] = '{
        "R8 lui+ori", "R5 add", "R5 sub", "R5 and", "R5 nor", "R7 slt true",
        "R7 slt false", "R6 sll", "R6 srl", "R8 andi zero-ext", "R4 r0 write",
        "R9 lw/sw base+offset", "R10 beq/bne taken", "R10 bne not taken",
        "R12 misaligned lw no write", "R13 illegal no effect", "R7 slti signed"
    };

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = '0;
            fetch_at[i] = -1;
        end
        mem[0]  = enc_i(6'h0F, 0, 1, 16'ha532);
        mem[1]  = enc_i(6'h0D, 1, 1, 16'h8d7e);
        mem[2]  = enc_i(6'h2B, 0, 1, 16'h0200);
        mem[3]  = enc_i(6'h08, 0, 2, 16'hfffb);
        mem[4]  = enc_i(6'h08, 0, 3, 16'h0007);
        mem[5]  = enc_r(6'h20, 2, 3, 4, 0);
        mem[6]  = enc_i(6'h2B, 0, 4, 16'h0204);
        mem[7]  = enc_r(6'h22, 2, 3, 5, 0);
        mem[8]  = enc_i(6'h2B, 0, 5, 16'h0208);
        mem[9]  = enc_r(6'h24, 1, 2, 6, 0);
        mem[10] = enc_i(6'h2B, 0, 6, 16'h020c);
        mem[11] = enc_r(6'h27, 1, 3, 7, 0);
        mem[12] = enc_i(6'h2B, 0, 7, 16'h0210);
        mem[13] = enc_r(6'h2A, 2, 3, 8, 0);
        mem[14] = enc_r(6'h2A, 3, 2, 9, 0);
        mem[15] = enc_i(6'h2B, 0, 8, 16'h0214);
        mem[16] = enc_i(6'h2B, 0, 9, 16'h0218);
        mem[17] = enc_r(6'h00, 0, 3, 10, 4);
        mem[18] = enc_r(6'h02, 0, 1, 11, 8);
        mem[19] = enc_i(6'h2B, 0, 10, 16'h021c);
        mem[20] = enc_i(6'h2B, 0, 11, 16'h0220);
        mem[21] = enc_i(6'h0C, 2, 12, 16'hff00);
        mem[22] = enc_i(6'h2B, 0, 12, 16'h0224);
        mem[23] = enc_i(6'h08, 0, 0, 16'h0005);
        mem[24] = enc_i(6'h2B, 0, 0, 16'h0228);
        mem[25] = enc_i(6'h08, 0, 13, 16'h0230);
        mem[26] = enc_i(6'h23, 13, 14, 16'hffd0);
        mem[27] = enc_i(6'h2B, 13, 14, 16'h0004);
        mem[28] = enc_i(6'h04, 2, 3, 16'h0001);
        mem[29] = enc_i(6'h04, 3, 3, 16'h0001);
        mem[30] = enc_i(6'h2B, 0, 3, 16'h0238);
        mem[31] = enc_i(6'h05, 2, 3, 16'h0001);
        mem[32] = enc_i(6'h2B, 0, 3, 16'h023c);
        mem[33] = enc_i(6'h2B, 0, 4, 16'h0238);
        mem[34] = enc_i(6'h05, 3, 3, 16'h0001);
        mem[35] = enc_i(6'h2B, 0, 7, 16'h023c);
        mem[36] = enc_j(26'd38);
        mem[37] = enc_i(6'h2B, 0, 3, 16'h0240);
        mem[38] = enc_i(6'h23, 0, 15, 16'h0202);
        mem[39] = enc_i(6'h2B, 0, 15, 16'h0240);
        mem[40] = enc_i(6'h2B, 0, 3, 16'h0245);
        mem[41] = {6'h3F, 26'd0};
        mem[42] = enc_r(6'h3F, 1, 2, 3, 0);
        mem[43] = enc_i(6'h2B, 0, 3, 16'h0244);
        mem[44] = enc_i(6'h0A, 2, 16, 16'hfffc);
        mem[45] = enc_i(6'h2B, 0, 16, 16'h0248);
        mem[46] = enc_j(26'd46);

        // R1: state under reset
        repeat (3) @(negedge clk);
        check("R1 reset misalign_err", {31'b0, misalign_err}, 32'h0);
        check("R1 reset illegal_op", {31'b0, illegal_op}, 32'h0);
        check("R1 reset pc on bus", mem_addr, 32'h0);
        rst_n = 1'b1;

        while (fetch_at[46] < 0) @(negedge clk);
        repeat (10) @(negedge clk);

        // vector table walk
        for (int i = 0; i < NW; i++) begin
            check({EXP_TAG[i], " addr"}, wlog_addr[i], EXP_WR[i][63:32]);
            check({EXP_TAG[i], " data"}, wlog_data[i], EXP_WR[i][31:0]);
        end

        // directed checks
        check("R1 first fetch address", first_addr, 32'h0);
        check("R2 alu instruction cycles", fetch_at[1] - fetch_at[0], 32'd5);
        check("R2 R9 load instruction cycles", fetch_at[27] - fetch_at[26], 32'd7);
        check("R3 R12 total writes", wcnt, NW);
        check("R10 beq skipped word", fetch_at[30], 32'hffffffff);
        check("R10 bne skipped word", fetch_at[32], 32'hffffffff);
        check("R11 jump skipped word", fetch_at[37], 32'hffffffff);
        check("R11 jump target fetched", {31'b0, fetch_at[38] >= 0}, 32'h1);
        check("R12 flag clear before", {31'b0, mis_at[38]}, 32'h0);
        check("R12 flag set after", {31'b0, mis_at[39]}, 32'h1);
        check("R12 flag sticky", {31'b0, mis_at[46]}, 32'h1);
        check("R13 flag clear before", {31'b0, ill_at[41]}, 32'h0);
        check("R13 flag set after", {31'b0, ill_at[42]}, 32'h1);

        // R1: reset again mid-run
        logging   = 1'b0;
        got_first = 1'b0;
        rst_n     = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 re-reset misalign_err", {31'b0, misalign_err}, 32'h0);
        check("R1 re-reset illegal_op", {31'b0, illegal_op}, 32'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 refetch address", first_addr, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule